// File: doc/BRIEF.md
# I2C Repeated Start Sequencer with Collision Detection

This block issues a Repeated Start on an I2C bus partway through a transfer, beginning from the point where this master holds SCL low after the last bit or acknowledge. A single-cycle request starts a three-phase timed sequence. First SDA is let go while SCL stays low. Then SCL is let go and the block waits until the line really reads high. Then, after a hold time, SDA is pulled low, and after a setup time SCL is pulled low again. Each phase lasts one run of a private down-counting baud timer, which is loaded from a 7-bit reload value.

While it runs, the block watches the sampled bus lines for two signs that another master is still arbitrating. The first is SDA reading low at the moment SCL is seen high, which means the other master is sending a '0'. The second is SCL dropping during the hold phase before this block has pulled SDA low, which means the other master is clocking a '1'. On either event the block lets go of both lines, raises a sticky collision flag and drops its busy bit. On normal completion it raises a sticky done flag and keeps both lines pulled low, so that the next address byte can follow. The line inputs must already be synchronised to `clk`. The pull-down outputs drive open-drain pads.

Top module: `rstart_gen`

## Requirements
- R1: While reset is asserted, and from its release until the first request, every output is 0: no pull-down, not busy, no flags. Asserting reset during a sequence ends it, with the same output values.
- R2: A request (`req_i`=1 while idle) is accepted at a clock edge. After that edge `busy_o`=1, `sda_pd_o`=0, `scl_pd_o`=1, and both flags are 0.
- R3: With reload value N, `scl_pd_o` stays 1 through edge N after acceptance and becomes 0 at edge N+1. Acceptance is edge 0.
- R4: Once SCL is released, nothing is sampled until `scl_i` reads 1. Each cycle that SCL is held low by another device delays every later event by one cycle.
- R5: If `sda_i` is 0 at the edge where `scl_i` is first seen high, a collision is declared at that edge.
- R6: During the hold count, which runs for the N+1 edges after SCL was seen high, `scl_i` reading 0 at any of those edges is a collision, including the last one.
- R7: `sda_i` pulled low by another master during the hold count is not a collision, and the sequence completes normally.
- R8: With no collision and no stretching, the sequence completes at edge 3N+4 after acceptance. At that edge `busy_o` becomes 0 and `irq_o` becomes 1, while `sda_pd_o`=1 and `scl_pd_o`=1 stay asserted. With S stretch cycles, completion is at edge 3N+4+S.
- R9: The level of `scl_i` during the final (setup) count has no effect, and completion timing is unchanged.
- R10: On a collision, at the same edge: `coll_o`=1, `sda_pd_o`=0, `scl_pd_o`=0, `busy_o`=0, and `irq_o` stays 0.
- R11: A request while `busy_o`=1 is ignored, and the sequence timing is unchanged.
- R12: `coll_o` and `irq_o` hold their value until the next accepted request clears them. They are never both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Single-cycle start request |
| reload_i | input | 7 | Baud timer reload value N |
| sda_i | input | 1 | Synchronised SDA line level |
| scl_i | input | 1 | Synchronised SCL line level |
| sda_pd_o | output | 1 | SDA pull-down enable |
| scl_pd_o | output | 1 | SCL pull-down enable |
| busy_o | output | 1 | Sequence running; clears itself |
| coll_o | output | 1 | Sticky bus collision flag |
| irq_o | output | 1 | Sticky completion flag |

## Verification
A wrong phase or a miscounted timer shows up directly as a pull-down edge in the wrong cycle. It then moves the completion edge away from 3N+4+S, and the bench sees that within one sequence, at most a few hundred cycles. A collision check placed in the wrong phase, or a missing check, leaves the pull-down and flag pattern wrong at the very edge where `busy_o` falls. A timer that wraps below zero stretches a phase by 2^7 cycles, which makes completion late by that amount.

// File: rtl/rstart_pkg.sv
package rstart_pkg;
  localparam int RS_RELOAD_W = 7;

  typedef enum logic [2:0] {
    RS_IDLE    = 3'd0,
    RS_REL_SDA = 3'd1,
    RS_REL_SCL = 3'd2,
    RS_HOLD    = 3'd3,
    RS_SETUP   = 3'd4
  } rs_state_e;
endpackage

// File: rtl/rstart_rst_sync.sv
module rstart_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= '0;
    else         sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_o = sync_q[STAGES-1];
endmodule

// File: rtl/rstart_baud.sv
module rstart_baud #(
  parameter int W = 7
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_i,
  input  logic [W-1:0] val_i,
  input  logic         step_i,
  output logic         zero_o
);
  logic [W-1:0] cnt_q, cnt_d;
  logic         cnt_en;

  always_comb begin
    cnt_d  = cnt_q;
    cnt_en = 1'b0;
    if (load_i) begin
      cnt_d  = val_i;
      cnt_en = 1'b1;
    end else if (step_i && (cnt_q != '0)) begin
      cnt_d  = cnt_q - 1'b1;
      cnt_en = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign zero_o = (cnt_q == '0);

  // R3: the timer parks at zero and never wraps unless reloaded
  p_no_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (zero_o && !load_i) |=> zero_o);
endmodule

// File: rtl/rstart_seq.sv
module rstart_seq
  import rstart_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic req_i,
  input  logic sda_i,
  input  logic scl_i,
  input  logic zero_i,
  output logic load_o,
  output logic step_o,
  output logic sda_pd_o,
  output logic scl_pd_o,
  output logic busy_o,
  output logic coll_o,
  output logic irq_o
);
  rs_state_e state_q, state_d;
  logic sda_pd_q, sda_pd_d;
  logic scl_pd_q, scl_pd_d;
  logic coll_q, coll_d;
  logic irq_q, irq_d;
  logic collide;

  always_comb begin
    state_d  = state_q;
    sda_pd_d = sda_pd_q;
    scl_pd_d = scl_pd_q;
    coll_d   = coll_q;
    irq_d    = irq_q;
    load_o   = 1'b0;
    step_o   = 1'b0;
    collide  = 1'b0;
    unique case (state_q)
      RS_IDLE: begin
        if (req_i) begin
          state_d  = RS_REL_SDA;
          sda_pd_d = 1'b0;
          scl_pd_d = 1'b1;
          coll_d   = 1'b0;
          irq_d    = 1'b0;
          load_o   = 1'b1;
        end
      end
      RS_REL_SDA: begin
        if (zero_i) begin
          state_d  = RS_REL_SCL;
          scl_pd_d = 1'b0;
        end else begin
          step_o = 1'b1;
        end
      end
      RS_REL_SCL: begin
        if (scl_i) begin
          if (!sda_i) begin
            collide = 1'b1;
          end else begin
            state_d = RS_HOLD;
            load_o  = 1'b1;
          end
        end
      end
      RS_HOLD: begin
        if (!scl_i) begin
          collide = 1'b1;
        end else if (zero_i) begin
          state_d  = RS_SETUP;
          sda_pd_d = 1'b1;
          load_o   = 1'b1;
        end else begin
          step_o = 1'b1;
        end
      end
      RS_SETUP: begin
        if (zero_i) begin
          state_d  = RS_IDLE;
          scl_pd_d = 1'b1;
          irq_d    = 1'b1;
        end else begin
          step_o = 1'b1;
        end
      end
      default: state_d = RS_IDLE;
    endcase
    if (collide) begin
      state_d  = RS_IDLE;
      sda_pd_d = 1'b0;
      scl_pd_d = 1'b0;
      coll_d   = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= RS_IDLE;
      sda_pd_q <= 1'b0;
      scl_pd_q <= 1'b0;
      coll_q   <= 1'b0;
      irq_q    <= 1'b0;
    end else begin
      state_q  <= state_d;
      sda_pd_q <= sda_pd_d;
      scl_pd_q <= scl_pd_d;
      coll_q   <= coll_d;
      irq_q    <= irq_d;
    end
  end

  assign sda_pd_o = sda_pd_q;
  assign scl_pd_o = scl_pd_q;
  assign busy_o   = (state_q != RS_IDLE);
  assign coll_o   = coll_q;
  assign irq_o    = irq_q;

  // R2: acceptance releases SDA, holds SCL and clears the flags
  p_accept_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == RS_IDLE && req_i) |=>
      (busy_o && !sda_pd_q && scl_pd_q && !coll_q && !irq_q));

  // R5: SDA low when SCL is first seen high is a collision
  p_sda_at_rise_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == RS_REL_SCL && scl_i && !sda_i) |=> coll_q);

  // R10: a collision leaves both lines free and the block idle
  p_coll_release_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(coll_q) |-> (!sda_pd_q && !scl_pd_q && !busy_o && !irq_q));

  // R8: completion keeps both lines pulled low
  p_done_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_q) |-> (sda_pd_q && scl_pd_q && !busy_o));

  // R12: the two flags are exclusive
  p_flag_excl_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !(coll_q && irq_q));

  // R11: a request in the middle of the hold count does not restart anything
  p_ignore_req_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == RS_HOLD && req_i && scl_i && !zero_i) |=> (state_q == RS_HOLD));
endmodule

// File: rtl/rstart_gen.sv
module rstart_gen
  import rstart_pkg::*;
#(
  parameter int RELOAD_W = RS_RELOAD_W
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_i,
  input  logic [RELOAD_W-1:0] reload_i,
  input  logic                sda_i,
  input  logic                scl_i,
  output logic                sda_pd_o,
  output logic                scl_pd_o,
  output logic                busy_o,
  output logic                coll_o,
  output logic                irq_o
);
  logic rst_n_s;
  logic tmr_load, tmr_step, tmr_zero;

  rstart_rst_sync #(.STAGES(2)) i_rst_sync (
    .clk     (clk),
    .arst_n  (rst_n),
    .rst_n_o (rst_n_s)
  );

  rstart_baud #(.W(RELOAD_W)) i_baud (
    .clk    (clk),
    .rst_n  (rst_n_s),
    .load_i (tmr_load),
    .val_i  (reload_i),
    .step_i (tmr_step),
    .zero_o (tmr_zero)
  );

  rstart_seq i_seq (
    .clk      (clk),
    .rst_n    (rst_n_s),
    .req_i    (req_i),
    .sda_i    (sda_i),
    .scl_i    (scl_i),
    .zero_i   (tmr_zero),
    .load_o   (tmr_load),
    .step_o   (tmr_step),
    .sda_pd_o (sda_pd_o),
    .scl_pd_o (scl_pd_o),
    .busy_o   (busy_o),
    .coll_o   (coll_o),
    .irq_o    (irq_o)
  );
endmodule

// File: tb/test_rstart_gen.sv
`timescale 1ns/1ps
module test_rstart_gen;
  localparam int RW = 7;
  localparam int NV = 10;
  // columns: reload N, stretch S, mode, offset h, expected collision, expected done edge
  // mode 0 clean, 1 SDA low at SCL rise, 2 SCL low in hold, 3 SDA low in hold, 4 SCL low in setup
  localparam int VT [NV][6] = '{
    '{3,   0, 0, 0, 0, 13},
    '{0,   0, 0, 0, 0, 4},
    '{5,   3, 0, 0, 0, 22},
    '{3,   0, 1, 0, 1, 5},
    '{4,   2, 1, 0, 1, 8},
    '{3,   0, 2, 1, 1, 6},
    '{3,   1, 2, 4, 1, 10},
    '{3,   0, 3, 2, 0, 13},
    '{2,   0, 4, 1, 0, 10},
    '{127, 0, 0, 0, 0, 385}
  };

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n, req;
  logic [RW-1:0] reload;
  logic ext_sda_low, ext_scl_low;
  logic sda_pd, scl_pd, busy, coll, irq;
  logic sda_line, scl_line;
  int n_run = 0;
  int n_fail = 0;

  assign sda_line = !(sda_pd || ext_sda_low);
  assign scl_line = !(scl_pd || ext_scl_low);

  rstart_gen i_rstart_gen (
    .clk(clk), .rst_n(rst_n), .req_i(req), .reload_i(reload),
    .sda_i(sda_line), .scl_i(scl_line),
    .sda_pd_o(sda_pd), .scl_pd_o(scl_pd), .busy_o(busy),
    .coll_o(coll), .irq_o(irq)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic bit scl_pull(int k, int n, int s, int mode, int h);
    return (k <= n + 1 + s) || (mode == 2 && k == n + 2 + s + h) ||
           (mode == 4 && k == 2 * n + 3 + s + h);
  endfunction

  function automatic bit sda_pull(int k, int n, int s, int mode, int h);
    return (mode == 1 && k <= n + 2 + s) || (mode == 3 && k == n + 2 + s + h);
  endfunction

  task automatic run_seq(input int n, input int s, input int mode, input int h,
                         input int exp_coll, input int exp_done, input int extra_req);
    int j;
    string tag;
    case (mode)
      1: tag = "R5";
      2: tag = "R6";
      3: tag = "R7";
      4: tag = "R9";
      default: tag = (s > 0) ? "R4" : "R8";
    endcase
    if (extra_req > 0) tag = "R11";
    @(negedge clk);
    reload = RW'(n);
    req = 1'b1;
    ext_scl_low = scl_pull(0, n, s, mode, h);
    ext_sda_low = sda_pull(0, n, s, mode, h);
    @(posedge clk);
    @(negedge clk);
    req = 1'b0;
    chk("R2 busy", busy, 1);
    chk("R2 sda_pd", sda_pd, 0);
    chk("R2 scl_pd", scl_pd, 1);
    chk("R2 flags", {30'd0, coll, irq}, 0);
    j = 0;
    while (busy && j < 2000) begin
      ext_scl_low = scl_pull(j + 1, n, s, mode, h);
      ext_sda_low = sda_pull(j + 1, n, s, mode, h);
      req = (extra_req == j + 1);
      @(posedge clk);
      @(negedge clk);
      j++;
      if (n > 0 && j == n) chk("R3 scl held", scl_pd, 1);
      if (j == n + 1) chk("R3 scl released", scl_pd, 0);
    end
    req = 1'b0;
    chk({tag, " done edge"}, j, exp_done);
    chk({tag, " R10 coll"}, coll, exp_coll);
    chk({tag, " R8 irq"}, irq, 1 - exp_coll);
    chk({tag, " sda_pd"}, sda_pd, 1 - exp_coll);
    chk({tag, " scl_pd"}, scl_pd, 1 - exp_coll);
    ext_scl_low = 1'b1;
    ext_sda_low = 1'b0;
    repeat (3) @(negedge clk);
    chk("R12 coll sticky", coll, exp_coll);
    chk("R12 irq sticky", irq, 1 - exp_coll);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired, sequence hung");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    req = 1'b0;
    reload = '0;
    ext_scl_low = 1'b1;
    ext_sda_low = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 outputs in reset", {27'd0, sda_pd, scl_pd, busy, coll, irq}, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 outputs after release", {27'd0, sda_pd, scl_pd, busy, coll, irq}, 0);

    for (int v = 0; v < NV; v++)
      run_seq(VT[v][0], VT[v][1], VT[v][2], VT[v][3], VT[v][4], VT[v][5], 0);

    // R11: extra request part-way through must not alter timing
    run_seq(3, 0, 0, 0, 0, 13, 5);
    run_seq(3, 0, 0, 0, 0, 13, 9);

    // R1: reset during a running sequence
    @(negedge clk);
    reload = RW'(6);
    req = 1'b1;
    @(negedge clk);
    req = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk("R1 reset mid-sequence", {27'd0, sda_pd, scl_pd, busy, coll, irq}, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 idle after mid reset", {27'd0, sda_pd, scl_pd, busy, coll, irq}, 0);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule